// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block decides when and how a periodic DRAM refresh runs in a system where a CPU shares memory with an expansion bus. A periodic tick marks each refresh interval. The scheduler holds that request and then runs the refresh in one of two ways. The first way requests the bus with a hold handshake. The second way, called hidden refresh, keeps the CPU running and stalls only those CPU accesses that would collide with the refresh.

Three static configuration inputs select the behaviour. They are hidden enable, wait for idle, and bus strobe suppression, and all three are low in the reset configuration. In the wait-for-idle mode, a hidden refresh waits for a CPU idle state. If no idle state comes within a deadline, the refresh starts when the current CPU cycle completes. When suppression is on, a hidden refresh drives no bus strobes and refreshes local memory only, so it is shorter. A refresh that starts while the bus is granted to another master always includes the bus strobes. DRAM timing, the refresh address counter and cache logic sit outside the block.

Top module: `refresh_sched`

## Requirements
- R1: During and directly after reset, `hold_req`, `ref_strobe`, `memr_strobe`, `wait_req` and `overrun` are all low. No refresh is pending, and the CPU is treated as idle.
- R2: With `cfg_hidden_en` low, a `ref_tick` sampled at clock edge k makes the refresh pending after edge k. `hold_req` rises after edge k+1 and stays high until `hlda` is sampled high. A 12-cycle bus refresh then runs, with `hold_req` still high. `hold_req` falls when the refresh ends.
- R3: With `cfg_hidden_en` high and `cfg_idle_wait` low, the refresh starts after edge k+1 without raising `hold_req`. CPU cycles that request neither local memory nor the bus (cache hits) are never stalled.
- R4: During a hidden refresh, `wait_req` is high in exactly those cycles where `cpu_mem_req` or `cpu_bus_req` is high. It responds in the same clock, with no register on the path. `wait_req` is never high outside a hidden refresh.
- R5: With `cfg_idle_wait` high, a pending hidden refresh starts at an edge only if the CPU is idle. Idle means that `cpu_ads` has not been seen since the last `cpu_ready`, that `cpu_ads` is low in the current cycle, and that `hlda` is low. `cpu_ads` takes priority over `cpu_ready` when both are high in the same cycle.
- R6: If a hidden refresh has been pending for TIMEOUT_CYC (16) cycles without an idle start, it starts at the first edge where `cpu_ready` is high.
- R7: With `cfg_bus_ref_off` high and `hlda` low at start, a hidden refresh lasts 4 cycles and drives neither `ref_strobe` nor `memr_strobe`.
- R8: A hidden refresh that starts while `hlda` is high lasts 12 cycles with both strobes high, whatever the value of `cfg_bus_ref_off`.
- R9: A `ref_tick` that arrives while a refresh is pending or running is dropped and sets `overrun`. `overrun` then stays high until reset.
- R10: Every refresh that includes the bus keeps `ref_strobe` and `memr_strobe` high together for exactly 12 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_hidden_en | input | 1 | 1 = hidden refresh, 0 = hold handshake refresh |
| cfg_idle_wait | input | 1 | 1 = hidden refresh waits for CPU idle or the deadline |
| cfg_bus_ref_off | input | 1 | 1 = omit bus strobes during hidden refresh |
| ref_tick | input | 1 | One-cycle periodic refresh request |
| cpu_ads | input | 1 | CPU address strobe (cycle start), active high |
| cpu_ready | input | 1 | CPU cycle completion, active high |
| cpu_mem_req | input | 1 | Current CPU access targets local memory |
| cpu_bus_req | input | 1 | Current CPU access targets the expansion bus |
| hlda | input | 1 | Hold acknowledge |
| hold_req | output | 1 | Hold request for the bus |
| ref_strobe | output | 1 | Refresh strobe, active high |
| memr_strobe | output | 1 | Memory-read strobe accompanying refresh, active high |
| wait_req | output | 1 | Wait-state request to the CPU |
| overrun | output | 1 | Sticky flag: a refresh tick was dropped |

## Verification
The hold handshake path is driven with an acknowledge that arrives late. This separates the wait for `hlda` from the fixed refresh length. Hidden refreshes are run with each mix of memory, bus and cache-hit CPU cycles, which tells a selective stall from a blanket one. Other runs vary the strobe suppression setting and the `hlda` level, so the 4-cycle local refresh can be told from the forced 12-cycle bus refresh. CPU streams that are busy and then idle, and streams that are busy for the whole pending time, separate an idle start from a deadline start; double ticks then test the overrun flag, and a long random stream mixes all of these.

// File: rtl/refresh_pkg.sv
// Shared types for the refresh scheduler.
// Assumes: one clock domain, synchronous active-low reset.
package refresh_pkg;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,   // nothing pending
        RS_PEND  = 2'd1,   // refresh latched, choosing how to start
        RS_HOLDW = 2'd2,   // hold requested, awaiting acknowledge
        RS_RUN   = 2'd3    // refresh cycle in progress
    } rs_state_t;

endpackage

// File: rtl/cpu_idle_mon.sv
// Tracks whether the CPU sits between cycles: a ready closes a cycle,
// an address strobe opens one. Strobe wins when both come together.
// Assumes: cpu_ads and cpu_ready are synchronous single-cycle pulses.
module cpu_idle_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_ads,
    input  logic cpu_ready,
    input  logic hlda,
    output logic cpu_idle
);
    logic between_q;

    // Remember whether the last cycle boundary seen was a ready.
    always_ff @(posedge clk) begin
        if (!rst_n)         between_q <= 1'b1;
        else if (cpu_ads)   between_q <= 1'b0;
        else if (cpu_ready) between_q <= 1'b1;
    end

    // Idle now: no cycle open, none starting, bus not granted away.
    assign cpu_idle = between_q && !cpu_ads && !hlda;
endmodule

// File: rtl/refresh_deadline.sv
// Counts cycles spent pending and flags when the idle wait is over.
// Assumes: active stays high only while the refresh is pending.
module refresh_deadline #(
    parameter int TIMEOUT_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic expired
);
    localparam int DW = $clog2(TIMEOUT_CYC + 1);
    logic [DW-1:0] cnt_q;

    // Saturating count of pending cycles, cleared when not pending.
    always_ff @(posedge clk) begin
        if (!rst_n || !active)             cnt_q <= '0;
        else if (cnt_q != DW'(TIMEOUT_CYC)) cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q == DW'(TIMEOUT_CYC));
endmodule

// File: rtl/refresh_run_timer.sv
// Times one refresh cycle: loaded with the length of a local or a bus
// refresh, counts down while running, flags the final cycle.
// Assumes: load and run are never high together.
module refresh_run_timer #(
    parameter int LOCAL_LEN = 4,
    parameter int BUS_LEN   = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic with_bus,
    input  logic run,
    output logic last
);
    localparam int MAXLEN = (BUS_LEN > LOCAL_LEN) ? BUS_LEN : LOCAL_LEN;
    localparam int CW     = $clog2(MAXLEN + 1);
    logic [CW-1:0] cnt_q;

    // Load remaining-cycle count at start, decrement each running cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= with_bus ? CW'(BUS_LEN - 1) : CW'(LOCAL_LEN - 1);
        else if (run && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/refresh_sched.sv
// Refresh scheduler top: latches refresh ticks and runs each refresh
// through the hold handshake or hidden, stalling only CPU accesses to
// local memory or the expansion bus.
// Assumes: configuration inputs are static while a refresh is pending.
module refresh_sched
    import refresh_pkg::*;
#(
    parameter int TIMEOUT_CYC = 16,
    parameter int LOCAL_LEN   = 4,
    parameter int BUS_LEN     = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_hidden_en,
    input  logic cfg_idle_wait,
    input  logic cfg_bus_ref_off,
    input  logic ref_tick,
    input  logic cpu_ads,
    input  logic cpu_ready,
    input  logic cpu_mem_req,
    input  logic cpu_bus_req,
    input  logic hlda,
    output logic hold_req,
    output logic ref_strobe,
    output logic memr_strobe,
    output logic wait_req,
    output logic overrun
);
    rs_state_t state_q, state_d;
    logic hidden_q, bus_q, ovr_q;
    logic cpu_idle, expired, last;
    logic start_hidden, start_hold, load, load_bus;

    cpu_idle_mon u_idle (
        .clk(clk), .rst_n(rst_n), .cpu_ads(cpu_ads),
        .cpu_ready(cpu_ready), .hlda(hlda), .cpu_idle(cpu_idle)
    );

    refresh_deadline #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_deadline (
        .clk(clk), .rst_n(rst_n),
        .active(state_q == RS_PEND), .expired(expired)
    );

    refresh_run_timer #(.LOCAL_LEN(LOCAL_LEN), .BUS_LEN(BUS_LEN)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .with_bus(load_bus),
        .run(state_q == RS_RUN), .last(last)
    );

    // Start conditions for the two refresh styles.
    always_comb begin
        start_hidden = (state_q == RS_PEND) && cfg_hidden_en &&
                       (!cfg_idle_wait || cpu_idle || (expired && cpu_ready));
        start_hold   = (state_q == RS_HOLDW) && hlda;
        load         = start_hidden || start_hold;
        load_bus     = start_hold || !cfg_bus_ref_off || hlda;
    end

    // Next-state selection for the scheduler.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE:  if (ref_tick) state_d = RS_PEND;
            RS_PEND:  if (!cfg_hidden_en) state_d = RS_HOLDW;
                      else if (start_hidden) state_d = RS_RUN;
            RS_HOLDW: if (start_hold) state_d = RS_RUN;
            RS_RUN:   if (last) state_d = RS_IDLE;
            default:  state_d = RS_IDLE;
        endcase
    end

    // State register plus attributes of the refresh in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= RS_IDLE;
            hidden_q <= 1'b0;
            bus_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load) begin
                hidden_q <= start_hidden;
                bus_q    <= load_bus;
            end
        end
    end

    // Sticky flag for ticks that arrive while one is still outstanding.
    always_ff @(posedge clk) begin
        if (!rst_n)                            ovr_q <= 1'b0;
        else if (ref_tick && state_q != RS_IDLE) ovr_q <= 1'b1;
    end

    // Output decode.
    always_comb begin
        hold_req    = (state_q == RS_HOLDW) || (state_q == RS_RUN && !hidden_q);
        ref_strobe  = (state_q == RS_RUN) && bus_q;
        memr_strobe = (state_q == RS_RUN) && bus_q;
        wait_req    = (state_q == RS_RUN) && hidden_q && (cpu_mem_req || cpu_bus_req);
        overrun     = ovr_q;
    end
endmodule

// File: rtl/refresh_sched_chk.sv
// Port-level protocol checks for refresh_sched, attached by bind.
// Assumes: default length parameters (bus refresh of 12 cycles).
module refresh_sched_chk #(
    parameter int BUS_LEN = 12
) (
    input logic clk,
    input logic rst_n,
    input logic cpu_mem_req,
    input logic cpu_bus_req,
    input logic hlda,
    input logic hold_req,
    input logic ref_strobe,
    input logic memr_strobe,
    input logic wait_req,
    input logic overrun
);
    logic [7:0] strobe_len;

    // Length of the current run of strobe cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)          strobe_len <= '0;
        else if (ref_strobe) strobe_len <= strobe_len + 1'b1;
        else                 strobe_len <= '0;
    end

    assert_wait_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wait_req |-> (cpu_mem_req || cpu_bus_req));

    assert_wait_no_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wait_req |-> !hold_req);

    assert_no_strobe_before_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_req && !ref_strobe && !hlda) |=> !ref_strobe);

    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    assert_strobes_paired_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ref_strobe == memr_strobe);

    assert_bus_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_strobe) |-> (strobe_len == 8'(BUS_LEN)));
endmodule

bind refresh_sched refresh_sched_chk #(.BUS_LEN(BUS_LEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_mem_req(cpu_mem_req),
    .cpu_bus_req(cpu_bus_req), .hlda(hlda), .hold_req(hold_req),
    .ref_strobe(ref_strobe), .memr_strobe(memr_strobe),
    .wait_req(wait_req), .overrun(overrun)
);

// File: tb/sim_refresh_sched.sv
// Bench: behavioural reference model compared on every clock.
module sim_refresh_sched;
    localparam int TO = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_hidden_en = 0, cfg_idle_wait = 0, cfg_bus_ref_off = 0;
    logic ref_tick = 0, cpu_ads = 0, cpu_ready = 0;
    logic cpu_mem_req = 0, cpu_bus_req = 0, hlda = 0;
    logic hold_req, ref_strobe, memr_strobe, wait_req, overrun;

    always #2.5 clk = ~clk;

    refresh_sched u0 (.*);

    int vectors = 0, miscompares = 0, cycles = 0;
    string phase = "R1 reset";
    bit done = 0;

    // Reference model state: integers only.
    int m_mode = 0;      // 0 none, 1 pending, 2 hold wait, 3 running
    int m_left = 0, m_pend = 0;
    bit m_hidden = 0, m_bus = 0, m_between = 1, m_ovr = 0;

    always @(posedge clk) begin
        bit idle_now;
        cycles++;
        if (!rst_n) begin
            m_mode = 0; m_left = 0; m_pend = 0;
            m_hidden = 0; m_bus = 0; m_between = 1; m_ovr = 0;
        end else begin
            idle_now = m_between && !cpu_ads && !hlda;
            if (ref_tick && m_mode != 0) m_ovr = 1;
            if (m_mode == 0) begin
                if (ref_tick) begin m_mode = 1; m_pend = 0; end
            end else if (m_mode == 1) begin
                if (!cfg_hidden_en) m_mode = 2;
                else if (!cfg_idle_wait || idle_now || (m_pend >= TO && cpu_ready)) begin
                    m_mode = 3; m_hidden = 1;
                    m_bus = !cfg_bus_ref_off || hlda;
                    m_left = m_bus ? 12 : 4;
                end else if (m_pend < TO) m_pend++;
            end else if (m_mode == 2) begin
                if (hlda) begin m_mode = 3; m_hidden = 0; m_bus = 1; m_left = 12; end
            end else begin
                m_left--;
                if (m_left == 0) m_mode = 0;
            end
            if (cpu_ads) m_between = 0;
            else if (cpu_ready) m_between = 1;
        end
    end

    task automatic cmp(string sig, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s at cycle %0d: actual %b expected %b",
                     phase, sig, cycles, act, exp);
        end
    endtask

    // Compare all outputs away from the active edge.
    always begin
        @(negedge clk);
        #1;
        if (!done) begin
            cmp("hold_req",    hold_req,    m_mode == 2 || (m_mode == 3 && !m_hidden));
            cmp("ref_strobe",  ref_strobe,  m_mode == 3 && m_bus);
            cmp("memr_strobe", memr_strobe, m_mode == 3 && m_bus);
            cmp("wait_req",    wait_req,    m_mode == 3 && m_hidden && (cpu_mem_req || cpu_bus_req));
            cmp("overrun",     overrun,     m_ovr);
        end
    end

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        if (cycles > 100000 && !done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick();
        ref_tick = 1; step(1); ref_tick = 0;
    endtask

    initial begin
        step(4);
        rst_n = 1;
        step(2);

        phase = "R2 hold handshake";
        tick(); step(5); hlda = 1; step(16); hlda = 0; step(3);

        phase = "R3 R4 hidden with mixed CPU cycles";
        cfg_hidden_en = 1;
        tick();
        for (int i = 0; i < 16; i++) begin
            cpu_mem_req = (i % 3 == 0); cpu_bus_req = (i % 5 == 1); step(1);
        end
        cpu_mem_req = 0; cpu_bus_req = 0; step(3);

        phase = "R7 local-only hidden";
        cfg_bus_ref_off = 1;
        tick(); cpu_bus_req = 1; step(8); cpu_bus_req = 0; step(2);

        phase = "R8 hidden during bus grant";
        hlda = 1; tick(); step(16); hlda = 0; step(2);

        phase = "R5 wait for idle";
        cfg_idle_wait = 1; cfg_bus_ref_off = 0;
        cpu_ads = 1; tick(); cpu_ads = 0; step(5);
        cpu_ready = 1; step(1); cpu_ready = 0; step(16);

        phase = "R6 deadline start";
        cpu_ads = 1; tick(); step(22); cpu_ready = 1; step(1); cpu_ready = 0;
        step(3); cpu_ads = 0; step(14);

        phase = "R9 overrun";
        cfg_idle_wait = 0;
        tick(); tick(); step(20);

        phase = "R10 random mix";
        for (int i = 0; i < 3000; i++) begin
            if (i % 250 == 0) begin
                cfg_hidden_en = $urandom_range(0, 1);
                cfg_idle_wait = $urandom_range(0, 1);
                cfg_bus_ref_off = $urandom_range(0, 1);
            end
            ref_tick    = ($urandom_range(0, 39) == 0);
            cpu_ads     = ($urandom_range(0, 3) == 0);
            cpu_ready   = ($urandom_range(0, 2) == 0);
            cpu_mem_req = $urandom_range(0, 1);
            cpu_bus_req = ($urandom_range(0, 3) == 0);
            hlda        = hold_req ? ($urandom_range(0, 2) != 0) : ($urandom_range(0, 19) == 0);
            step(1);
        end
        ref_tick = 0; hlda = 0;
        step(2);

        phase = "R1 reset again";
        rst_n = 0; step(2);
        finish_run();
    end
endmodule